// File: doc/BRIEF.md
# Shared Packet Buffer Hub

This block is the central packet store for a group of network interfaces. All buffered packets live in one dual-port RAM. One port writes and the other reads. Interfaces take turns: a rotating pointer names one interface per clock. In that cycle the hub can accept one packet cell from that interface's receive side and can issue one read for that interface's transmit side. The receive write uses the write port and the transmit read uses the read port, so both happen in the same cycle.

Empty buffer slots come from a free-slot queue. At reset this queue holds every slot. An accepted packet takes the slot at the head of the queue, and its data is written there. The slot index is then appended to the outgoing queue of the destination interface that the sender names. Each outgoing queue is a FIFO of slot indices, and its depth is capped at a fraction of the total slot count. When the transmit side of an interface is serviced, the hub reads the oldest slot in its queue and hands that slot back to the free-slot queue. The data appears one cycle later, tagged with the interface index.

Each interface decides for itself when a packet is complete. It raises its receive request only for a finished packet and holds it until the hub either accepts the packet or drops it. In this block one slot holds one packet word.

Top module: `pkt_hub`

## Requirements
- R1: While reset is low and in the first cycle after it, tx_valid, rx_done and rx_drop are all low. After reset every outgoing queue is empty, so raising tx_ready on all interfaces produces no tx_valid. The free-slot queue holds all NUM_SLOTS slots.
- R2: A service pointer steps through interface indices 0, 1, …, NUM_IF-1, 0, … and advances by one every clock, whether or not there is work. Only the pointed-to interface can see rx_done or rx_drop in a cycle. With all outgoing queues non-empty and all tx_ready high, tx_valid comes in back-to-back cycles with tx_if increasing by one modulo NUM_IF.
- R3: When an interface with rx_valid high is serviced, a free slot exists and the destination queue is below its cap, rx_done pulses for that interface for one cycle. The word is stored and its slot is appended to the queue of the interface named by that sender's rx_dest field.
- R4: When an interface with tx_ready high and a non-empty outgoing queue is serviced, tx_valid is high in the next cycle. In that cycle tx_if equals that interface index and tx_data is the stored word.
- R5: Each outgoing queue delivers its words in the order in which they were accepted.
- R6: Receive acceptance and transmit read for the same serviced interface happen in one cycle.
- R7: If no free slot remains when an interface with rx_valid high is serviced, rx_drop pulses for it, rx_done stays low and nothing is stored.
- R8: Each outgoing queue holds at most NUM_SLOTS/TXQ_DIV slots. A packet aimed at a full queue is dropped with rx_drop, and its slot stays in the free-slot queue.
- R9: A slot read out for transmission returns to the free-slot queue. The slots held free plus those queued always total NUM_SLOTS, so after draining, the full capacity can be filled again.
- R10: rx_done and rx_drop are never both high for one interface, and at most one bit across both vectors is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | NUM_IF | Per interface: a complete packet word is waiting |
| rx_dest | input | NUM_IF*IF_W | Per interface: destination interface index, IF_W bits each, interface i at bits [i*IF_W +: IF_W] |
| rx_data | input | NUM_IF*DATA_W | Per interface: packet word, interface i at bits [i*DATA_W +: DATA_W] |
| rx_done | output | NUM_IF | One-cycle pulse: the packet was stored |
| rx_drop | output | NUM_IF | One-cycle pulse: the packet was refused |
| tx_ready | input | NUM_IF | Per interface: transmit side can take a word |
| tx_valid | output | 1 | tx_data and tx_if are valid this cycle |
| tx_if | output | IF_W | Interface index the word is for |
| tx_data | output | DATA_W | Word read from the buffer |

## Verification
A corrupted free-slot queue shows up as two packets sharing a slot: a later packet overwrites an earlier one, and the earlier packet comes out with the wrong word when its queue drains. It can also show up as a slot leak, where the capacity refill after a drain drops a packet before NUM_SLOTS words are held. A wrong outgoing-queue pointer breaks order or data on the next transmit of that interface, one cycle after its service slot. A pointer that skips or repeats breaks the back-to-back tx_if sequence at once. The bench therefore fills the buffer to the last slot, drains it, fills it again, and compares every delivered word and tag against its own per-destination model.

// File: rtl/hub_pkg.sv
// Shared types for the packet hub.
// Assumes: nothing beyond IEEE 1800-2017.
package hub_pkg;

    // What happened to the receive request of the serviced interface
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_STORE = 2'd1,
        RX_DROP  = 2'd2
    } rx_outcome_e;

endpackage

// File: rtl/hub_rr_sched.sv
// Rotating service pointer: names one interface per clock and steps by one
// every cycle, with or without work.
// Assumes: NUM_IF >= 2.
module hub_rr_sched #(
    parameter int NUM_IF = 4,
    localparam int IF_W  = $clog2(NUM_IF)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [IF_W-1:0]   sel,
    output logic [NUM_IF-1:0] grant
);

    localparam logic [IF_W-1:0] LAST = IF_W'(NUM_IF - 1);

    logic [IF_W-1:0] ptr_q;

    // Advance the pointer and wrap after the last interface
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (ptr_q == LAST)
            ptr_q <= '0;
        else
            ptr_q <= ptr_q + 1'b1;
    end

    // One-hot decode of the pointer
    always_comb begin
        for (int k = 0; k < NUM_IF; k++)
            grant[k] = (ptr_q == IF_W'(k));
    end

    assign sel = ptr_q;

endmodule

// File: rtl/hub_slot_fifo.sv
// FIFO of slot indices. It serves as the free-slot queue (PRELOAD=1, which
// fills it with 0..DEPTH-1 at reset) and as an outgoing queue (PRELOAD=0,
// empty at reset).
// Assumes: the user never pops when empty and never pushes when full
// unless a pop happens in the same cycle.
module hub_slot_fifo #(
    parameter int DEPTH   = 8,
    parameter int W       = 4,
    parameter bit PRELOAD = 1'b0,
    localparam int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] cnt_q;

    // Pointer, count and storage update; the preload lives in the reset branch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= PRELOAD ? CW'(DEPTH) : '0;
            for (int k = 0; k < DEPTH; k++)
                store[k] <= PRELOAD ? W'(k) : '0;
        end else begin
            if (push) begin
                store[wr_ptr] <= push_data;
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop)
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = store[rd_ptr];
    assign count = cnt_q;
    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);

endmodule

// File: rtl/hub_dp_ram.sv
// Packet word memory with one write port and one read port.
// The read is registered, so data follows the address by one cycle.
// Assumes: the two ports never target the same address in one cycle.
// Contents are not reset.
module hub_dp_ram #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] cells [DEPTH];

    // Write port
    always_ff @(posedge clk) begin
        if (wr_en)
            cells[wr_addr] <= wr_data;
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (rd_en)
            rd_data <= cells[rd_addr];
    end

endmodule

// File: rtl/pkt_hub.sv
// Shared packet buffer hub. Each cycle it services one interface, chosen by
// a rotating pointer, on both receive and transmit. Slots come from a
// free-slot queue, and each destination keeps a capped FIFO of slot indices.
// Assumes: senders hold rx_valid, rx_dest and rx_data until rx_done or
// rx_drop; NUM_SLOTS is a power of two; TXQ_DIV divides NUM_SLOTS.
module pkt_hub #(
    parameter int NUM_IF    = 4,
    parameter int NUM_SLOTS = 16,
    parameter int DATA_W    = 32,
    parameter int TXQ_DIV   = 2,
    localparam int IF_W     = $clog2(NUM_IF),
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int TXQ_CAP  = NUM_SLOTS / TXQ_DIV,
    localparam int FCW      = $clog2(NUM_SLOTS + 1),
    localparam int QCW      = $clog2(TXQ_CAP + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IF-1:0]        rx_valid,
    input  logic [NUM_IF*IF_W-1:0]   rx_dest,
    input  logic [NUM_IF*DATA_W-1:0] rx_data,
    output logic [NUM_IF-1:0]        rx_done,
    output logic [NUM_IF-1:0]        rx_drop,
    input  logic [NUM_IF-1:0]        tx_ready,
    output logic                     tx_valid,
    output logic [IF_W-1:0]          tx_if,
    output logic [DATA_W-1:0]        tx_data
);
    import hub_pkg::*;

    // Service pointer
    logic [IF_W-1:0]   sel;
    logic [NUM_IF-1:0] grant;

    hub_rr_sched #(.NUM_IF(NUM_IF)) u_sched (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .grant (grant)
    );

    // Serviced interface's request fields
    logic              req_rx;
    logic [IF_W-1:0]   req_dest;
    logic [DATA_W-1:0] req_data;

    assign req_rx   = rx_valid[sel];
    assign req_dest = rx_dest[sel*IF_W +: IF_W];
    assign req_data = rx_data[sel*DATA_W +: DATA_W];

    // Free-slot queue
    logic              free_push;
    logic [SLOT_W-1:0] free_push_slot;
    logic              free_pop;
    logic [SLOT_W-1:0] free_head;
    logic [FCW-1:0]    free_cnt;
    logic              free_full;
    logic              free_empty;

    hub_slot_fifo #(
        .DEPTH   (NUM_SLOTS),
        .W       (SLOT_W),
        .PRELOAD (1'b1)
    ) u_free_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (free_push),
        .push_data (free_push_slot),
        .pop       (free_pop),
        .head      (free_head),
        .count     (free_cnt),
        .full      (free_full),
        .empty     (free_empty)
    );

    // Outgoing queues, one per interface
    logic [SLOT_W-1:0]     txq_head  [NUM_IF];
    logic [NUM_IF-1:0]     txq_full;
    logic [NUM_IF-1:0]     txq_empty;
    logic [NUM_IF-1:0]     txq_push;
    logic [NUM_IF-1:0]     txq_pop;
    logic [NUM_IF*QCW-1:0] txq_cnt;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_IF; gi++) begin : g_txq
            hub_slot_fifo #(
                .DEPTH   (TXQ_CAP),
                .W       (SLOT_W),
                .PRELOAD (1'b0)
            ) u_txq (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (txq_push[gi]),
                .push_data (free_head),
                .pop       (txq_pop[gi]),
                .head      (txq_head[gi]),
                .count     (txq_cnt[gi*QCW +: QCW]),
                .full      (txq_full[gi]),
                .empty     (txq_empty[gi])
            );
        end
    endgenerate

    // Receive decision for the serviced interface
    rx_outcome_e outcome;

    always_comb begin
        if (!req_rx)
            outcome = RX_IDLE;
        else if (free_empty || txq_full[req_dest])
            outcome = RX_DROP;
        else
            outcome = RX_STORE;
    end

    // Transmit decision for the serviced interface
    logic              tx_go;
    logic [SLOT_W-1:0] tx_slot;

    assign tx_go   = tx_ready[sel] && !txq_empty[sel];
    assign tx_slot = txq_head[sel];

    // Queue controls: allocate on store, release on transmit read
    assign free_pop       = (outcome == RX_STORE);
    assign free_push      = tx_go;
    assign free_push_slot = tx_slot;

    // Per-queue push (destination of a stored word) and pop (serviced reader)
    always_comb begin
        for (int k = 0; k < NUM_IF; k++) begin
            txq_push[k] = (outcome == RX_STORE) && (req_dest == IF_W'(k));
            txq_pop[k]  = tx_go && grant[k];
        end
    end

    // Handshake pulses back to the serviced interface
    assign rx_done = grant & {NUM_IF{outcome == RX_STORE}};
    assign rx_drop = grant & {NUM_IF{outcome == RX_DROP}};

    // Packet memory: write port for receive, read port for transmit
    hub_dp_ram #(
        .DEPTH (NUM_SLOTS),
        .W     (DATA_W)
    ) u_ram (
        .clk     (clk),
        .wr_en   (free_pop),
        .wr_addr (free_head),
        .wr_data (req_data),
        .rd_en   (tx_go),
        .rd_addr (tx_slot),
        .rd_data (tx_data)
    );

    // Transmit valid and tag, aligned with the one-cycle RAM read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_if    <= '0;
        end else begin
            tx_valid <= tx_go;
            tx_if    <= sel;
        end
    end

endmodule

// File: rtl/pkt_hub_chk.sv
// Property checker for pkt_hub, attached by bind. Relates the service
// pointer, the queue occupancies and the port handshakes over time.
// Assumes: connected to the internal pointer and counts of pkt_hub.
module pkt_hub_chk #(
    parameter int NUM_IF    = 4,
    parameter int NUM_SLOTS = 16,
    parameter int TXQ_CAP   = 8,
    localparam int IF_W     = $clog2(NUM_IF),
    localparam int FCW      = $clog2(NUM_SLOTS + 1),
    localparam int QCW      = $clog2(TXQ_CAP + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [IF_W-1:0]       sel,
    input logic [NUM_IF-1:0]     rx_done,
    input logic [NUM_IF-1:0]     rx_drop,
    input logic [NUM_IF-1:0]     tx_ready,
    input logic                  tx_valid,
    input logic [IF_W-1:0]       tx_if,
    input logic [FCW-1:0]        free_cnt,
    input logic                  free_full,
    input logic [NUM_IF*QCW-1:0] txq_cnt
);

    // Slots held across all outgoing queues
    int queued;
    always_comb begin
        queued = 0;
        for (int k = 0; k < NUM_IF; k++)
            queued = queued + int'(txq_cnt[k*QCW +: QCW]);
    end

    // Pointer as a one-hot vector for comparison with the handshakes
    logic [NUM_IF-1:0] sel_hot;
    assign sel_hot = NUM_IF'(1) << sel;

    AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sel == (($past(sel) == IF_W'(NUM_IF - 1)) ? '0 : $past(sel) + 1'b1)); // R2

    AST_SERVICE_ON_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_done | rx_drop) != '0) |-> ((rx_done | rx_drop) == sel_hot)); // R2

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_done | rx_drop) && ((rx_done & rx_drop) == '0)); // R10

    AST_TX_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && tx_valid) |-> (tx_if == $past(sel)) && $past(tx_ready[sel])); // R4

    AST_NO_ALLOC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt == '0) |-> (rx_done == '0)); // R7

    AST_SLOT_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_cnt) + queued == NUM_SLOTS); // R9

    AST_FULL_FREE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        free_full |-> (txq_cnt == '0)); // R9

    genvar gk;
    generate
        for (gk = 0; gk < NUM_IF; gk++) begin : g_cap
            AST_TXQ_CAP: assert property (@(posedge clk) disable iff (!rst_n)
                int'(txq_cnt[gk*QCW +: QCW]) <= TXQ_CAP); // R8
        end
    endgenerate

endmodule

bind pkt_hub pkt_hub_chk #(
    .NUM_IF    (NUM_IF),
    .NUM_SLOTS (NUM_SLOTS),
    .TXQ_CAP   (TXQ_CAP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .rx_done  (rx_done),
    .rx_drop  (rx_drop),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_if    (tx_if),
    .free_cnt (free_cnt),
    .free_full(free_full),
    .txq_cnt  (txq_cnt)
);

// File: tb/pkt_hub_tb_top.sv
// Directed bench for pkt_hub: one task per scenario, each checking its own
// results against a per-destination model kept in the bench.
module pkt_hub_tb_top;

    localparam int NUM_IF    = 4;
    localparam int NUM_SLOTS = 16;
    localparam int DATA_W    = 32;
    localparam int TXQ_DIV   = 2;
    localparam int IF_W      = 2;
    localparam int CAP       = NUM_SLOTS / TXQ_DIV;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NUM_IF-1:0]        rx_valid = '0;
    logic [NUM_IF*IF_W-1:0]   rx_dest = '0;
    logic [NUM_IF*DATA_W-1:0] rx_data = '0;
    logic [NUM_IF-1:0]        rx_done;
    logic [NUM_IF-1:0]        rx_drop;
    logic [NUM_IF-1:0]        tx_ready = '0;
    logic                     tx_valid;
    logic [IF_W-1:0]          tx_if;
    logic [DATA_W-1:0]        tx_data;

    pkt_hub #(
        .NUM_IF    (NUM_IF),
        .NUM_SLOTS (NUM_SLOTS),
        .DATA_W    (DATA_W),
        .TXQ_DIV   (TXQ_DIV)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_dest  (rx_dest),
        .rx_data  (rx_data),
        .rx_done  (rx_done),
        .rx_drop  (rx_drop),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_if    (tx_if),
        .tx_data  (tx_data)
    );

    // 250 MHz clock
    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;
    logic [31:0] seq = 32'h5A00_0000;

    // Model: expected words per destination, in acceptance order
    logic [DATA_W-1:0] exp_mem [NUM_IF][64];
    int exp_wr [NUM_IF];
    int exp_rd [NUM_IF];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Present one word from src to dst and wait for the outcome
    task automatic send(input int src, input int dst, input bit exp_ok, input string req);
        logic [DATA_W-1:0] d;
        bit got_done, got_drop;
        d = seq;
        seq = seq + 32'h0001_0003;
        got_done = 1'b0;
        got_drop = 1'b0;
        @(negedge clk);
        rx_valid[src] = 1'b1;
        rx_dest[src*IF_W +: IF_W] = IF_W'(dst);
        rx_data[src*DATA_W +: DATA_W] = d;
        for (int t = 0; t < 20; t++) begin
            #0;
            if (rx_done[src] || rx_drop[src]) begin
                got_done = rx_done[src];
                got_drop = rx_drop[src];
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        rx_valid[src] = 1'b0;
        check(got_done == exp_ok && got_drop == !exp_ok, req,
              {62'd0, got_done, got_drop}, {62'd0, exp_ok, !exp_ok});
        if (got_done) begin
            exp_mem[dst][exp_wr[dst] % 64] = d;
            exp_wr[dst]++;
        end
    endtask

    // Drain n words from one interface, checking tag, data and order
    task automatic drain(input int ifx, input int n);
        int got;
        got = 0;
        @(negedge clk);
        tx_ready[ifx] = 1'b1;
        for (int t = 0; t < 8 * n + 16 && got < n; t++) begin
            @(negedge clk);
            if (tx_valid) begin
                check(tx_if == IF_W'(ifx), "R4 tx_if tag", 64'(tx_if), 64'(ifx));
                check(tx_data == exp_mem[ifx][exp_rd[ifx] % 64], "R5 order and data",
                      64'(tx_data), 64'(exp_mem[ifx][exp_rd[ifx] % 64]));
                exp_rd[ifx]++;
                got++;
            end
        end
        tx_ready[ifx] = 1'b0;
        check(got == n, "R3 words delivered", 64'(got), 64'(n));
    endtask

    // All ready for a while: nothing may come out (queues empty)
    task automatic expect_idle(input string req);
        int seen;
        seen = 0;
        @(negedge clk);
        tx_ready = '1;
        for (int t = 0; t < 12; t++) begin
            @(negedge clk);
            if (tx_valid) seen++;
        end
        tx_ready = '0;
        check(seen == 0, req, 64'(seen), 64'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(tx_valid == 1'b0 && rx_done == '0 && rx_drop == '0, "R1 outputs in reset",
              {rx_done, rx_drop, 55'd0, tx_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_valid == 1'b0, "R1 tx_valid after reset", 64'(tx_valid), 64'd0);
        expect_idle("R1 queues empty after reset");
    endtask

    task automatic t_basic();
        send(0, 2, 1'b1, "R3 store 0->2");
        send(3, 2, 1'b1, "R3 store 3->2");
        send(1, 2, 1'b1, "R3 store 1->2");
        drain(2, 3);
    endtask

    task automatic t_round_robin();
        int first_if, cnt;
        bit consec;
        for (int k = 0; k < NUM_IF; k++) begin
            send(k, k, 1'b1, "R3 fill for rotation");
            send((k + 1) % NUM_IF, k, 1'b1, "R3 fill for rotation");
        end
        @(negedge clk);
        tx_ready = '1;
        for (int t = 0; t < 10 && !tx_valid; t++) @(negedge clk);
        first_if = int'(tx_if);
        consec = 1'b1;
        cnt = 0;
        for (int t = 0; t < 8; t++) begin
            if (!tx_valid || tx_if != IF_W'((first_if + t) % NUM_IF)) consec = 1'b0;
            if (tx_valid) begin
                check(tx_data == exp_mem[tx_if][exp_rd[tx_if] % 64], "R5 data in rotation",
                      64'(tx_data), 64'(exp_mem[tx_if][exp_rd[tx_if] % 64]));
                exp_rd[tx_if]++;
                cnt++;
            end
            @(negedge clk);
        end
        tx_ready = '0;
        check(consec, "R2 back-to-back rotating tx_if", 64'(cnt), 64'd8);
    endtask

    task automatic t_same_cycle();
        bit saw_done;
        logic [DATA_W-1:0] d;
        send(0, 1, 1'b1, "R3 preload queue 1");
        send(2, 1, 1'b1, "R3 preload queue 1");
        d = seq;
        seq = seq + 32'h0001_0003;
        saw_done = 1'b0;
        @(negedge clk);
        tx_ready[1] = 1'b1;
        rx_valid[1] = 1'b1;
        rx_dest[1*IF_W +: IF_W] = 2'd1;
        rx_data[1*DATA_W +: DATA_W] = d;
        for (int t = 0; t < 8 && !saw_done; t++) begin
            #0;
            if (rx_done[1]) saw_done = 1'b1;
            else @(negedge clk);
        end
        @(negedge clk);
        rx_valid[1] = 1'b0;
        tx_ready[1] = 1'b0;
        check(saw_done, "R6 receive accepted", 64'(saw_done), 64'd1);
        check(tx_valid && tx_if == 2'd1, "R6 transmit in the same service",
              {62'd0, tx_valid, 1'b0} | 64'(tx_if), 64'h3);
        if (tx_valid) exp_rd[1]++;
        exp_mem[1][exp_wr[1] % 64] = d;
        exp_wr[1]++;
        check(tx_data == exp_mem[1][(exp_rd[1] - 1) % 64], "R6 oldest word first",
              64'(tx_data), 64'(exp_mem[1][(exp_rd[1] - 1) % 64]));
        drain(1, 2);
    endtask

    task automatic t_capacity();
        for (int k = 0; k < CAP; k++) send(k % NUM_IF, 0, 1'b1, "R3 fill queue 0");
        for (int k = 0; k < CAP; k++) send((k + 1) % NUM_IF, 1, 1'b1, "R3 fill queue 1");
        send(2, 2, 1'b0, "R7 drop with no free slot");
        drain(0, CAP);
        drain(1, CAP);
        // Refill: queue 3 to its cap, then one more to it
        for (int k = 0; k < CAP; k++) send(k % NUM_IF, 3, 1'b1, "R9 refill after drain");
        send(1, 3, 1'b0, "R8 drop at queue cap");
        // The refused word consumed no slot: a full CAP still fits in queue 2
        for (int k = 0; k < CAP; k++) send((k + 2) % NUM_IF, 2, 1'b1, "R8 no slot lost on refusal");
        send(0, 0, 1'b0, "R7 drop when pool exhausted again");
        drain(3, CAP);
        drain(2, CAP);
        expect_idle("R9 all queues empty after drain");
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int k = 0; k < NUM_IF; k++) begin
            exp_wr[k] = 0;
            exp_rd[k] = 0;
        end
        t_reset();
        t_basic();
        t_round_robin();
        t_same_cycle();
        t_capacity();
        // R10 is also checked by the bound checker every cycle
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule